// File: doc/BRIEF.md
# Transmit descriptor ring walker

This block fetches transmit descriptors from a ring in shared memory and turns them into packets. Each descriptor is four 32-bit words: word 0 holds an ownership flag, word 1 holds the control flags and two byte counts, and words 2 and 3 hold the addresses of up to two data buffers. The walker reads descriptors through a word-addressed memory port, copies the referenced bytes into a local packet store, and plays each finished packet out as a byte stream. It then hands the descriptors back to software by writing zero over their ownership word.

Software loads the ring base, sets the run enable and pulses `kick` to start a scan pass. A pass handles packets one after another until it meets a descriptor the walker does not own, until the run enable drops, or until the per-pass packet limit is reached. A packet may span several descriptors. A lone descriptor with both segment flags clear carries configuration data rather than traffic: its first buffer is streamed out on a separate word output. Every completed packet sets a sticky status bit and pulses an interrupt line.

Top module: `txring_walker`

## Requirements
- R1: After reset the block is idle: `tx_busy`, `mem_req`, `pkt_valid`, `setup_valid`, `tx_irq` and `tx_status` are all 0.
- R2: `ring_load`, when sampled while idle, makes `ring_base` the current descriptor address. `kick` starts a pass only if `tx_run` is 1 and `ring_base` is nonzero. Otherwise no memory access takes place.
- R3: If word 0 bit 31 of the first descriptor of a packet is 0, the pass ends after that single read, with no write and no packet.
- R4: Buffer 1 has length word 1 [10:0] and address word 2. Buffer 2 has length word 1 [21:11] and address word 3. Buffer 1 bytes are gathered before buffer 2 bytes, and each memory word gives its bits [31:24] first. Buffer addresses are word-aligned. Buffer 2 is skipped when word 1 bit 24 is set.
- R5: The next descriptor is chosen as follows: the ring base if word 1 bit 25 is set; otherwise word 3 if bit 24 is set; otherwise the current address plus 16.
- R6: Gathering carries on into the following descriptor until a descriptor has word 1 bit 30 or bit 27 set. Each descriptor after the first has its word 0 written to zero as soon as its data has been gathered.
- R7: Word 0 of a packet's first descriptor is written to zero only after the packet has been played out. At that point `tx_status` is set and `tx_irq` pulses for one cycle. `tx_status_clr` clears `tx_status`.
- R8: If a later descriptor of a packet has word 0 bit 31 clear, the packet is dropped. The first descriptor stays owned, there is no interrupt, and the pass ends.
- R9: A first descriptor with word 1 bits 29 and 30 both clear is a setup descriptor. If its bit 27 is set, ceil(len1/4) words of buffer 1 appear on `setup_word` with `setup_valid`. In every case no packet is emitted, its word 0 is written to zero, and the interrupt follows.
- R10: A packet whose total length is zero emits nothing on the byte output, but its descriptors are still released and the interrupt still follows.
- R11: A packet longer than `PKT_BYTES` is cut to its first `PKT_BYTES` bytes.
- R12: One pass handles at most `MAX_PASS` packets. Descriptors beyond that limit stay owned until the next `kick`.
- R13: `mem_req` with `mem_addr` and `mem_we` stays stable until `mem_ack`, and drops in the cycle after it. Only one access is outstanding at a time.
- R14: A packet leaves as consecutive `pkt_valid` cycles, one byte per cycle, with `pkt_last` on its final byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_run | input | 1 | Transmit run enable |
| kick | input | 1 | Start one scan pass |
| ring_load | input | 1 | Load current descriptor address from ring base |
| ring_base | input | 32 | Ring base byte address |
| tx_status_clr | input | 1 | Clear the sticky completion status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data (ownership release) |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of packet |
| setup_valid | output | 1 | Setup word valid |
| setup_word | output | 32 | Setup buffer word |
| tx_irq | output | 1 | One-cycle completion interrupt |
| tx_status | output | 1 | Sticky completion status |
| tx_busy | output | 1 | A pass is in progress |

## Verification
The bench builds the walker with a 16-byte packet store and a limit of three packets per pass. With these values a 20-byte packet reaches the truncation limit, and four ready descriptors are enough to show a pass stopping early and the next kick finishing the work. The memory model answers after zero, one or two wait cycles in turn, so request holding is exercised across different latencies. Descriptor chains cover sequential, linked and wrapping next-address choices, a dropped packet, setup descriptors and an empty packet.

// File: rtl/txw_pkg.sv
package txw_pkg;
    // Descriptor flag positions (word 0 / word 1)
    localparam int OWN_B   = 31;
    localparam int LAST_B  = 30;
    localparam int FIRST_B = 29;
    localparam int SETUP_B = 27;
    localparam int WRAP_B  = 25;
    localparam int LINK_B  = 24;

    typedef enum logic [3:0] {
        S_IDLE, S_NEXT, S_DESC, S_PLAN, S_GREQ, S_GBYTE,
        S_RELN, S_ADV, S_SETUP, S_EMIT, S_RELF
    } state_e;
endpackage

// File: rtl/txw_next.sv
module txw_next (
    input  logic [31:0] cur,
    input  logic [31:0] base,
    input  logic [31:0] link,
    input  logic        wrap,
    input  logic        chain,
    output logic [31:0] nxt
);
    // ring wrap wins over chaining, chaining over sequential
    always_comb begin
        if (wrap)       nxt = base;
        else if (chain) nxt = link;
        else            nxt = cur + 32'd16;
    end
endmodule

// File: rtl/txw_pktbuf.sv
module txw_pktbuf #(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
    parameter int PKT_BYTES = 2048,
    parameter int MAX_PASS  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_run,
    input  logic        kick,
    input  logic        ring_load,
    input  logic [31:0] ring_base,
    input  logic        tx_status_clr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [29:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        pkt_valid,
    output logic [7:0]  pkt_data,
    output logic        pkt_last,
    output logic        setup_valid,
    output logic [31:0] setup_word,
    output logic        tx_irq,
    output logic        tx_status,
    output logic        tx_busy
);
    import txw_pkg::*;

    localparam int LEN_W  = $clog2(PKT_BYTES + 1);
    localparam int AW     = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;
    localparam int PASS_W = $clog2(MAX_PASS + 1);
    localparam logic [LEN_W-1:0]  CAP      = LEN_W'(PKT_BYTES);
    localparam logic [PASS_W-1:0] PASS_LIM = PASS_W'(MAX_PASS);

    typedef struct packed {
        state_e            st;
        logic [31:0]       cur;
        logic [31:0]       start;
        logic [31:0]       w1;
        logic [31:0]       w2;
        logic [31:0]       w3;
        logic [31:0]       baddr;
        logic [10:0]       brem;
        logic [31:0]       word;
        logic [1:0]        bi;
        logic [1:0]        widx;
        logic              bsel;
        logic              first;
        logic              sup;
        logic [LEN_W-1:0]  plen;
        logic [LEN_W-1:0]  rptr;
        logic [PASS_W-1:0] pass;
        logic              mreq;
        logic              mwe;
        logic [29:0]       maddr;
        logic              pv;
        logic [7:0]        pd;
        logic              plast;
        logic              sv;
        logic [31:0]       sw;
        logic              irq;
        logic              stat;
    } walk_t;

    walk_t q, d;
    logic        bw_en;
    logic [7:0]  buf_rdata;
    logic [31:0] nxt;

    txw_next u_next (
        .cur   (q.cur),
        .base  (ring_base),
        .link  (q.w3),
        .wrap  (q.w1[WRAP_B]),
        .chain (q.w1[LINK_B]),
        .nxt   (nxt)
    );

    txw_pktbuf #(.DEPTH(PKT_BYTES)) u_buf (
        .clk   (clk),
        .we    (bw_en),
        .waddr (q.plen[AW-1:0]),
        .wdata (q.word[31:24]),
        .raddr (q.rptr[AW-1:0]),
        .rdata (buf_rdata)
    );

    always_comb begin
        d       = q;
        d.pv    = 1'b0;
        d.plast = 1'b0;
        d.sv    = 1'b0;
        d.irq   = 1'b0;
        bw_en   = 1'b0;
        if (tx_status_clr) d.stat = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (ring_load) d.cur = ring_base;
                if (kick) begin
                    d.pass = '0;
                    d.st   = S_NEXT;
                end
            end
            S_NEXT: begin
                if (!tx_run || ring_base == 32'd0 || q.pass == PASS_LIM) begin
                    d.st = S_IDLE;
                end else begin
                    d.start = q.cur;
                    d.first = 1'b1;
                    d.plen  = '0;
                    d.widx  = '0;
                    d.st    = S_DESC;
                end
            end
            S_DESC: begin
                if (!q.mreq) begin
                    d.mreq  = 1'b1;
                    d.mwe   = 1'b0;
                    d.maddr = q.cur[31:2] + 30'(q.widx);
                end else if (mem_ack) begin
                    d.mreq = 1'b0;
                    d.widx = q.widx + 2'd1;
                    case (q.widx)
                        2'd0: if (!mem_rdata[OWN_B]) d.st = S_IDLE;
                        2'd1: d.w1 = mem_rdata;
                        2'd2: d.w2 = mem_rdata;
                        default: begin
                            d.w3 = mem_rdata;
                            d.st = S_PLAN;
                        end
                    endcase
                end
            end
            S_PLAN: begin
                d.baddr = q.w2;
                d.brem  = q.w1[10:0];
                d.bsel  = 1'b0;
                d.sup   = q.first && !q.w1[FIRST_B] && !q.w1[LAST_B];
                if (q.first && !q.w1[FIRST_B] && !q.w1[LAST_B])
                    d.st = (q.w1[SETUP_B] && q.w1[10:0] != 11'd0) ? S_SETUP : S_ADV;
                else
                    d.st = S_GREQ;
            end
            S_GREQ: begin
                if (q.brem == 11'd0) begin
                    if (!q.bsel) begin
                        d.bsel  = 1'b1;
                        d.baddr = q.w3;
                        d.brem  = q.w1[LINK_B] ? 11'd0 : q.w1[21:11];
                    end else begin
                        d.st = S_RELN;
                    end
                end else if (!q.mreq) begin
                    d.mreq  = 1'b1;
                    d.mwe   = 1'b0;
                    d.maddr = q.baddr[31:2];
                end else if (mem_ack) begin
                    d.mreq = 1'b0;
                    d.word = mem_rdata;
                    d.bi   = '0;
                    d.st   = S_GBYTE;
                end
            end
            S_GBYTE: begin
                if (q.plen < CAP) begin
                    bw_en  = 1'b1;
                    d.plen = q.plen + LEN_W'(1);
                end
                d.brem = q.brem - 11'd1;
                d.word = {q.word[23:0], 8'h00};
                d.bi   = q.bi + 2'd1;
                if (q.brem == 11'd1 || q.bi == 2'd3) begin
                    d.baddr = q.baddr + 32'd4;
                    d.st    = S_GREQ;
                end
            end
            S_RELN: begin
                if (q.first) begin
                    d.st = S_ADV;
                end else if (!q.mreq) begin
                    d.mreq  = 1'b1;
                    d.mwe   = 1'b1;
                    d.maddr = q.cur[31:2];
                end else if (mem_ack) begin
                    d.mreq = 1'b0;
                    d.st   = S_ADV;
                end
            end
            S_ADV: begin
                d.cur  = nxt;
                d.rptr = '0;
                if (q.sup || q.w1[LAST_B] || q.w1[SETUP_B]) begin
                    d.st = (!q.sup && q.plen != '0) ? S_EMIT : S_RELF;
                end else begin
                    d.first = 1'b0;
                    d.widx  = '0;
                    d.st    = S_DESC;
                end
            end
            S_SETUP: begin
                if (!q.mreq) begin
                    d.mreq  = 1'b1;
                    d.mwe   = 1'b0;
                    d.maddr = q.baddr[31:2];
                end else if (mem_ack) begin
                    d.mreq  = 1'b0;
                    d.sv    = 1'b1;
                    d.sw    = mem_rdata;
                    d.baddr = q.baddr + 32'd4;
                    if (q.brem <= 11'd4) begin
                        d.brem = '0;
                        d.st   = S_ADV;
                    end else begin
                        d.brem = q.brem - 11'd4;
                    end
                end
            end
            S_EMIT: begin
                d.pv    = 1'b1;
                d.pd    = buf_rdata;
                d.plast = (q.rptr == q.plen - LEN_W'(1));
                d.rptr  = q.rptr + LEN_W'(1);
                if (q.rptr == q.plen - LEN_W'(1)) d.st = S_RELF;
            end
            S_RELF: begin
                if (!q.mreq) begin
                    d.mreq  = 1'b1;
                    d.mwe   = 1'b1;
                    d.maddr = q.start[31:2];
                end else if (mem_ack) begin
                    d.mreq = 1'b0;
                    d.irq  = 1'b1;
                    d.stat = 1'b1;
                    d.pass = q.pass + PASS_W'(1);
                    d.st   = S_NEXT;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req     = q.mreq;
    assign mem_we      = q.mwe;
    assign mem_addr    = q.maddr;
    assign mem_wdata   = 32'd0;
    assign pkt_valid   = q.pv;
    assign pkt_data    = q.pd;
    assign pkt_last    = q.plast;
    assign setup_valid = q.sv;
    assign setup_word  = q.sw;
    assign tx_irq      = q.irq;
    assign tx_status   = q.stat;
    assign tx_busy     = (q.st != S_IDLE);
endmodule

// File: rtl/txw_checker.sv
module txw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_busy,
    input logic        tx_status_clr,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input logic [29:0] mem_addr,
    input logic        pkt_valid,
    input logic        pkt_last,
    input logic        setup_valid,
    input logic        tx_irq,
    input logic        tx_status
);
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r13_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !mem_req && !pkt_valid && !setup_valid);

    a_r14_last_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |-> pkt_valid);

    a_r14_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_last |=> pkt_valid);

    a_r9_outputs_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && setup_valid));

    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_status && !tx_status_clr |=> tx_status);
endmodule

bind txring_walker txw_checker u_chk (.*);

// File: tb/sim_txring_walker.sv
`timescale 1ns/1ps
module sim_txring_walker;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] LST  = 32'h4000_0000;
    localparam logic [31:0] FST  = 32'h2000_0000;
    localparam logic [31:0] SETB = 32'h0800_0000;
    localparam logic [31:0] WRP  = 32'h0200_0000;
    localparam logic [31:0] LNK  = 32'h0100_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_run = 1'b0, kick = 1'b0, ring_load = 1'b0, tx_status_clr = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic mem_req, mem_we, mem_ack;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic pkt_valid, pkt_last, setup_valid, tx_irq, tx_status, tx_busy;
    logic [7:0] pkt_data;
    logic [31:0] setup_word;

    always #4 clk = ~clk;

    txring_walker #(.PKT_BYTES(16), .MAX_PASS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_run(tx_run), .kick(kick),
        .ring_load(ring_load), .ring_base(ring_base), .tx_status_clr(tx_status_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
        .setup_valid(setup_valid), .setup_word(setup_word),
        .tx_irq(tx_irq), .tx_status(tx_status), .tx_busy(tx_busy)
    );

    logic [31:0] mem [0:1023];
    int nchk = 0, nerr = 0;
    int nacc, nwr, viol = 0, ncap, npkt, nsetup, nirq, gap = 0;
    logic [7:0]  cap  [0:63];
    logic [31:0] scap [0:15];
    logic [29:0] wlog [0:15];
    bit finished = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'(a ^ (a >> 8) ^ 8'h5A);
    endfunction

    // memory responder: one access at a time, latency cycles 0,1,2 in turn
    initial begin
        bit pend = 0;
        logic [29:0] padr;
        logic pwe;
        int wc, lat = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!pend) begin
                    pend = 1; padr = mem_addr; pwe = mem_we; wc = lat;
                    lat = (lat + 1) % 3;
                end else if (mem_addr !== padr || mem_we !== pwe) begin
                    viol++;
                end
                if (wc == 0) begin
                    mem_ack = 1'b1;
                    if (pwe) begin
                        mem[padr[9:0]] = mem_wdata;
                        if (nwr < 16) wlog[nwr] = padr;
                        nwr++;
                    end else begin
                        mem_rdata = mem[padr[9:0]];
                    end
                    pend = 0;
                    nacc++;
                end else begin
                    wc--;
                end
            end else if (pend) begin
                viol++;
            end
        end
    end

    // output monitor
    initial begin
        bit inpkt = 0;
        forever begin
            @(negedge clk);
            if (pkt_valid) begin
                if (ncap < 64) cap[ncap] = pkt_data;
                ncap++;
                if (pkt_last) npkt++;
                inpkt = !pkt_last;
            end else if (inpkt) begin
                gap++;
                inpkt = 0;
            end
            if (setup_valid) begin
                if (nsetup < 16) scap[nsetup] = setup_word;
                nsetup++;
            end
            if (tx_irq) nirq++;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic chk_bytes(input string r, input int idx0, input int addr, input int n);
        for (int i = 0; i < n; i++) chk(r, 32'(cap[idx0 + i]), 32'(pat(addr + i)));
    endtask

    task automatic clr;
        nacc = 0; nwr = 0; ncap = 0; npkt = 0; nsetup = 0; nirq = 0;
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[a >> 2] = w0; mem[(a >> 2) + 1] = w1;
        mem[(a >> 2) + 2] = w2; mem[(a >> 2) + 3] = w3;
    endtask

    task automatic run_pass;
        clr();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        for (int i = 0; i < 3000 && tx_busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 busy", 32'(tx_busy), 0);
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 pkt_valid", 32'(pkt_valid), 0);
        chk("R1 setup_valid", 32'(setup_valid), 0);
        chk("R1 irq", 32'(tx_irq), 0);
        chk("R1 status", 32'(tx_status), 0);
    endtask

    task automatic t_disabled;
        put_desc(32'h100, OWN, FST | LST | 32'd1, 32'h400, 0);
        tx_run = 1'b0;
        run_pass();
        chk("R2 no access when run off", nacc, 0);
        chk("R2 no packet when run off", npkt, 0);
        tx_run = 1'b1; ring_base = 32'h0;
        run_pass();
        chk("R2 no access when base zero", nacc, 0);
        ring_base = 32'h100;
    endtask

    task automatic t_two_buffers;
        put_desc(32'h100, OWN, FST | LST | 32'd5 | (32'd3 << 11), 32'h400, 32'h500);
        run_pass();
        chk("R4 byte count", ncap, 8);
        chk("R14 one packet", npkt, 1);
        chk_bytes("R4 buffer1", 0, 32'h400, 5);
        chk_bytes("R4 buffer2", 5, 32'h500, 3);
        chk("R7 first released", mem[32'h100 >> 2], 0);
        chk("R7 status", 32'(tx_status), 1);
        chk("R7 irq", nirq, 1);
        put_desc(32'h110, OWN, FST | LST | 32'd2, 32'h600, 0);
        run_pass();
        chk("R5 sequential next", ncap, 2);
        chk_bytes("R5 sequential data", 0, 32'h600, 2);
    endtask

    task automatic t_chain;
        put_desc(32'h120, OWN, FST | LST | LNK | 32'd4 | (32'd6 << 11), 32'h440, 32'h200);
        put_desc(32'h200, OWN, FST | LST | 32'd3, 32'h480, 0);
        run_pass();
        chk("R4 buffer2 skipped when chained", ncap, 7);
        chk("R5 chain packets", npkt, 2);
        chk_bytes("R5 chain data a", 0, 32'h440, 4);
        chk_bytes("R5 chain data b", 4, 32'h480, 3);
        chk("R5 chained desc released", mem[32'h200 >> 2], 0);
    endtask

    task automatic t_not_owned;
        run_pass();
        chk("R3 single read", nacc, 1);
        chk("R3 no write", nwr, 0);
        chk("R3 no packet", npkt, 0);
    endtask

    task automatic t_multi;
        put_desc(32'h210, OWN, FST | 32'd3, 32'h700, 0);
        put_desc(32'h220, OWN, 32'd2, 32'h704, 0);
        put_desc(32'h230, OWN, LST | 32'd4, 32'h708, 0);
        run_pass();
        chk("R6 packet count", npkt, 1);
        chk("R6 byte count", ncap, 9);
        chk_bytes("R6 seg1", 0, 32'h700, 3);
        chk_bytes("R6 seg2", 3, 32'h704, 2);
        chk_bytes("R6 seg3", 5, 32'h708, 4);
        chk("R6 write count", nwr, 3);
        chk("R6 middle released first", 32'(wlog[0]), 32'h220 >> 2);
        chk("R6 last released second", 32'(wlog[1]), 32'h230 >> 2);
        chk("R7 first released last", 32'(wlog[2]), 32'h210 >> 2);
    endtask

    task automatic t_abandon_wrap;
        @(negedge clk) tx_status_clr = 1'b1;
        @(negedge clk) tx_status_clr = 1'b0;
        chk("R7 status cleared", 32'(tx_status), 0);
        put_desc(32'h240, OWN, FST | 32'd2, 32'h720, 0);
        run_pass();
        chk("R8 no packet", npkt, 0);
        chk("R8 first still owned", mem[32'h240 >> 2], OWN);
        chk("R8 no irq", nirq, 0);
        chk("R8 no status", 32'(tx_status), 0);
        chk("R8 no write", nwr, 0);
        put_desc(32'h250, OWN, FST | LST | WRP | 32'd1, 32'h730, 0);
        run_pass();
        chk("R5 wrap packet", npkt, 1);
        chk_bytes("R5 wrap data", 0, 32'h730, 1);
        put_desc(32'h100, OWN, FST | LST | 32'd1, 32'h740, 0);
        run_pass();
        chk("R5 wrap reaches base", npkt, 1);
        chk_bytes("R5 base data", 0, 32'h740, 1);
    endtask

    task automatic t_setup;
        put_desc(32'h110, OWN, SETB | 32'd6, 32'h760, 0);
        run_pass();
        chk("R9 setup words", nsetup, 2);
        chk("R9 setup word0", scap[0], mem[32'h760 >> 2]);
        chk("R9 setup word1", scap[1], mem[(32'h760 >> 2) + 1]);
        chk("R9 no packet", ncap, 0);
        chk("R9 released", mem[32'h110 >> 2], 0);
        chk("R9 irq", nirq, 1);
        put_desc(32'h120, OWN, 32'd4, 32'h770, 0);
        run_pass();
        chk("R9 plain skip no words", nsetup, 0);
        chk("R9 plain skip released", mem[32'h120 >> 2], 0);
        chk("R9 plain skip irq", nirq, 1);
        chk("R9 plain skip no packet", ncap, 0);
    endtask

    task automatic t_zero;
        put_desc(32'h130, OWN, FST | LST, 32'h780, 0);
        run_pass();
        chk("R10 no bytes", ncap, 0);
        chk("R10 released", mem[32'h130 >> 2], 0);
        chk("R10 irq", nirq, 1);
    endtask

    task automatic t_trunc;
        put_desc(32'h140, OWN, FST | LST | 32'd12 | (32'd8 << 11), 32'h780, 32'h7C0);
        run_pass();
        chk("R11 truncated length", ncap, 16);
        chk("R11 one packet", npkt, 1);
        chk_bytes("R11 head", 0, 32'h780, 12);
        chk_bytes("R11 tail", 12, 32'h7C0, 4);
    endtask

    task automatic t_cap;
        put_desc(32'h150, OWN, FST | LST | 32'd1, 32'h7A0, 0);
        put_desc(32'h160, OWN, FST | LST | 32'd1, 32'h7A4, 0);
        put_desc(32'h170, OWN, FST | LST | 32'd1, 32'h7A8, 0);
        put_desc(32'h180, OWN, FST | LST | 32'd1, 32'h7AC, 0);
        run_pass();
        chk("R12 pass limited", npkt, 3);
        chk("R12 fourth still owned", mem[32'h180 >> 2], OWN);
        run_pass();
        chk("R12 next pass", npkt, 1);
        chk_bytes("R12 next pass data", 0, 32'h7AC, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 1024; w++)
            mem[w] = (w < 256) ? 32'd0 :
                     {pat(4*w), pat(4*w + 1), pat(4*w + 2), pat(4*w + 3)};
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        ring_load = 1'b1;
        @(negedge clk) ring_load = 1'b0;
        t_disabled();
        t_two_buffers();
        t_chain();
        t_not_owned();
        t_multi();
        t_abandon_wrap();
        t_setup();
        t_zero();
        t_trunc();
        t_cap();
        chk("R13 handshake violations", viol, 0);
        chk("R14 byte gaps", gap, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule